// File: doc/BRIEF.md
# Multi-Mode Serial I/Q Word Deserializer

This block sits in front of an upconverter channel and turns serial baseband samples back into parallel in-phase (I) and quadrature (Q) words. Each word is sent most significant bit first and has a programmable length of 1 to 32 bits. Only the upper 18 received bits are kept as sample data. A divided bit clock outside the block supplies a one-cycle `bit_en` strobe for each bit period. A `frame_start` marker, qualified by that strobe, says that the pins carry the first (most significant) bit of a new word.

The same capture engine serves three pin mappings, chosen by `mode`:

- **Two-channel (`00`).** Pin `sd_a` carries channel A and pin `sd_b` carries channel B. On each pin the I word comes first, then the Q word.
- **Single-channel (`01`, and `11` behaves the same).** `sd_a` carries I and `sd_b` carries Q at the same time.
- **Four-pin (`10`).** I is split across `sd_a` (MSB, MSB-2, ...) and `sd_b` (MSB-1, MSB-3, ...). Q is split the same way across `sd_c` and `sd_d`. This halves the number of bit periods per word.

When a word (or I/Q pair) is complete, the block registers the words, left-aligned into 18 bits, and raises a one-cycle valid pulse. `mode` and `word_bits` are held stable while a word is in flight.

The controller has four states:

- **`ST_IDLE`** waits for a qualified `frame_start`. From there it moves to `ST_GET_I` in two-channel mode, or to `ST_GET_IQ` otherwise.
- **`ST_GET_I`** moves to `ST_GET_Q` once the last I bit is taken.
- **`ST_GET_Q`** and **`ST_GET_IQ`** return to `ST_IDLE` on the last bit and raise the done pulse.
- **Any state** re-enters capture at bit 0 on a qualified `frame_start`, which acts as a restart.

Top module: `iq_serial_deser`

## Requirements
- R1: While `rst_n` is low, and until the first completed word, `a_i`, `a_q`, `b_i` and `b_q` read 0 and `a_valid` and `b_valid` are low.
- R2: Pins and `frame_start` are sampled only on cycles where `bit_en` is 1; with `bit_en` at 0, a high `frame_start` or any pin value has no effect.
- R3: Word length is `word_bits`+1 bits, sent MSB first; for lengths of 18 or more, the output is the first 18 bits received, and later bits are discarded.
- R4: For lengths under 18, the received word fills the top bits of the 18-bit output (bit 17 = received MSB) and the lower bits are 0.
- R5: In mode `00`, `sd_a` carries A-I then A-Q and `sd_b` carries B-I then B-Q, taking 2×length bit periods; `a_valid` and `b_valid` both pulse in the cycle after the last bit.
- R6: In modes `01` and `11`, `sd_a` carries I and `sd_b` carries Q, taking length bit periods; only `a_valid` pulses.
- R7: In mode `10`, bit period p puts I bit 2p (counted from the MSB) on `sd_a` and I bit 2p+1 on `sd_b`, and Q the same way on `sd_c` and `sd_d`; a word takes ceil(length/2) bit periods, and for odd lengths the last `sd_b`/`sd_d` bit is ignored.
- R8: A qualified `frame_start` always takes its bit as the MSB of a new word, discarding any partial word; qualified bits arriving in `ST_IDLE` without `frame_start` are ignored.
- R9: The valid pulse lasts one cycle unless another word completes on the very next bit; the `a_i`/`a_q` outputs change only in a cycle where `a_valid` is high.
- R10: `b_i`, `b_q` and `b_valid` change only in mode `00`; in other modes they hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Lane mapping: 00 two-channel, 01/11 single-channel, 10 four-pin |
| word_bits | input | 5 | Word length minus one |
| bit_en | input | 1 | Bit-period strobe from the divided bit clock |
| frame_start | input | 1 | Marks the MSB bit period of a new word (qualified by bit_en) |
| sd_a | input | 1 | Serial pin A |
| sd_b | input | 1 | Serial pin B |
| sd_c | input | 1 | Serial pin C (four-pin mode, Q high bits) |
| sd_d | input | 1 | Serial pin D (four-pin mode, Q low bits) |
| a_i | output | 18 | Channel A in-phase word |
| a_q | output | 18 | Channel A quadrature word |
| a_valid | output | 1 | One-cycle pulse: channel A words updated |
| b_i | output | 18 | Channel B in-phase word |
| b_q | output | 18 | Channel B quadrature word |
| b_valid | output | 1 | One-cycle pulse: channel B words updated |

## Verification
The bench goes after the following corner cases:

- **32-bit words.** A design that kept the low bits instead of the first 18 would show the wrong value.
- **Short 4- and 12-bit words.** A design that right-aligned them would lose the sign position.
- **A one-bit word and an odd 17-bit word in four-pin mode.** A design that wrote the spare `sd_b`/`sd_d` bit would corrupt the LSB, and one that used floor instead of ceil would finish a period early.
- **A restart issued mid-word.** A design that kept the partial bits would mix two words.
- **A stretch of strobed bits with no marker.** A design that captured them would raise a stray valid.
- **Back-to-back one-bit words on consecutive strobes.** These must give two adjacent valid pulses with different data.
- **Channel B outputs during single and four-pin traffic.** A design that updated them would change the held B words.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

    typedef enum logic [1:0] {
        LANE_DUAL       = 2'b00,
        LANE_SINGLE     = 2'b01,
        LANE_QUAD       = 2'b10,
        LANE_SINGLE_ALT = 2'b11
    } lane_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GET_I,
        ST_GET_Q,
        ST_GET_IQ
    } cap_state_e;

endpackage

// File: rtl/iqd_ctrl.sv
module iqd_ctrl
    import iqd_pkg::*;
#(
    parameter int MAX_BITS = 32,
    localparam int LEN_W   = $clog2(MAX_BITS),
    localparam int IDX_W   = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] word_bits,
    input  logic             bit_en,
    input  logic             frame_start,
    output logic             clear,
    output logic             cap_i,
    output logic             cap_q,
    output logic             pair_ok,
    output logic [IDX_W-1:0] pos,
    output logic             done
);

    cap_state_e       state_q, state_n, phase;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic [IDX_W-1:0] nbits, step;
    logic             is_dual, is_quad, active;

    assign is_dual = (lane_mode_e'(mode) == LANE_DUAL);
    assign is_quad = (lane_mode_e'(mode) == LANE_QUAD);
    assign nbits   = IDX_W'(word_bits) + IDX_W'(1);
    assign step    = is_quad ? IDX_W'(2) : IDX_W'(1);

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

    // Next-state and output process
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        phase   = state_q;
        pos     = idx_q;
        active  = 1'b0;
        clear   = 1'b0;
        cap_i   = 1'b0;
        cap_q   = 1'b0;
        done    = 1'b0;
        if (bit_en) begin
            if (frame_start) begin
                clear  = 1'b1;
                active = 1'b1;
                pos    = '0;
                phase  = is_dual ? ST_GET_I : ST_GET_IQ;
            end else if (state_q != ST_IDLE) begin
                active = 1'b1;
            end
        end
        if (active) begin
            unique case (phase)
                ST_IDLE:   ;
                ST_GET_I:  cap_i = 1'b1;
                ST_GET_Q:  cap_q = 1'b1;
                ST_GET_IQ: begin
                    cap_i = 1'b1;
                    cap_q = 1'b1;
                end
            endcase
            if (pos + step >= nbits) begin
                idx_n = '0;
                if (phase == ST_GET_I) begin
                    state_n = ST_GET_Q;
                end else begin
                    state_n = ST_IDLE;
                    done    = 1'b1;
                end
            end else begin
                state_n = phase;
                idx_n   = pos + step;
            end
        end
        pair_ok = is_quad && ((pos + IDX_W'(1)) < nbits);
    end

endmodule

// File: rtl/iqd_lane.sv
module iqd_lane #(
    parameter int MAX_BITS = 32,
    localparam int LEN_W   = $clog2(MAX_BITS),
    localparam int IDX_W   = LEN_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                wr,
    input  logic                pair_ok,
    input  logic [IDX_W-1:0]    pos,
    input  logic                bit_hi,
    input  logic                bit_lo,
    output logic [MAX_BITS-1:0] acc_next
);

    logic [MAX_BITS-1:0] acc_q;
    logic [LEN_W-1:0]    hi_idx, lo_idx;

    assign hi_idx = LEN_W'(MAX_BITS - 1 - int'(pos));
    assign lo_idx = LEN_W'(MAX_BITS - 2 - int'(pos));

    // Left-justified placement: bit at position p lands at MAX_BITS-1-p
    always_comb begin
        acc_next = clear ? '0 : acc_q;
        if (wr && (int'(pos) < MAX_BITS)) begin
            acc_next[hi_idx] = bit_hi;
            if (pair_ok && (int'(pos) + 1 < MAX_BITS)) begin
                acc_next[lo_idx] = bit_lo;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_next;
    end

endmodule

// File: rtl/iq_serial_deser.sv
module iq_serial_deser
    import iqd_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int OUT_W    = 18,
    localparam int LEN_W   = $clog2(MAX_BITS),
    localparam int IDX_W   = LEN_W + 1,
    localparam int N_LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] word_bits,
    input  logic             bit_en,
    input  logic             frame_start,
    input  logic             sd_a,
    input  logic             sd_b,
    input  logic             sd_c,
    input  logic             sd_d,
    output logic [OUT_W-1:0] a_i,
    output logic [OUT_W-1:0] a_q,
    output logic             a_valid,
    output logic [OUT_W-1:0] b_i,
    output logic [OUT_W-1:0] b_q,
    output logic             b_valid
);

    localparam int LN_AI = 0;
    localparam int LN_AQ = 1;
    localparam int LN_BI = 2;
    localparam int LN_BQ = 3;

    logic             clear, cap_i, cap_q, pair_ok, done;
    logic [IDX_W-1:0] pos;
    logic             is_dual, is_quad;

    logic [N_LANES-1:0] lane_wr, lane_hi, lane_lo;
    logic [MAX_BITS-1:0] lane_acc [N_LANES];

    assign is_dual = (lane_mode_e'(mode) == LANE_DUAL);
    assign is_quad = (lane_mode_e'(mode) == LANE_QUAD);

    iqd_ctrl #(.MAX_BITS(MAX_BITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .word_bits   (word_bits),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .clear       (clear),
        .cap_i       (cap_i),
        .cap_q       (cap_q),
        .pair_ok     (pair_ok),
        .pos         (pos),
        .done        (done)
    );

    // Pin-to-lane routing per mode
    always_comb begin
        lane_wr[LN_AI] = cap_i;
        lane_hi[LN_AI] = sd_a;
        lane_lo[LN_AI] = sd_b;

        lane_wr[LN_AQ] = cap_q;
        lane_hi[LN_AQ] = is_dual ? sd_a : (is_quad ? sd_c : sd_b);
        lane_lo[LN_AQ] = sd_d;

        lane_wr[LN_BI] = cap_i && is_dual;
        lane_hi[LN_BI] = sd_b;
        lane_lo[LN_BI] = 1'b0;

        lane_wr[LN_BQ] = cap_q && is_dual;
        lane_hi[LN_BQ] = sd_b;
        lane_lo[LN_BQ] = 1'b0;
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        iqd_lane #(.MAX_BITS(MAX_BITS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .wr       (lane_wr[g]),
            .pair_ok  (pair_ok),
            .pos      (pos),
            .bit_hi   (lane_hi[g]),
            .bit_lo   (lane_lo[g]),
            .acc_next (lane_acc[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_i     <= '0;
            a_q     <= '0;
            b_i     <= '0;
            b_q     <= '0;
            a_valid <= 1'b0;
            b_valid <= 1'b0;
        end else begin
            a_valid <= done;
            b_valid <= done && is_dual;
            if (done) begin
                a_i <= lane_acc[LN_AI][MAX_BITS-1 -: OUT_W];
                a_q <= lane_acc[LN_AQ][MAX_BITS-1 -: OUT_W];
                if (is_dual) begin
                    b_i <= lane_acc[LN_BI][MAX_BITS-1 -: OUT_W];
                    b_q <= lane_acc[LN_BQ][MAX_BITS-1 -: OUT_W];
                end
            end
        end
    end

endmodule

// File: rtl/iq_serial_deser_chk.sv
module iq_serial_deser_chk #(
    parameter int MAX_BITS = 32,
    parameter int OUT_W    = 18,
    localparam int LEN_W   = $clog2(MAX_BITS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [LEN_W-1:0] word_bits,
    input logic             bit_en,
    input logic             a_valid,
    input logic             b_valid,
    input logic [OUT_W-1:0] a_i,
    input logic [OUT_W-1:0] a_q,
    input logic [OUT_W-1:0] b_i,
    input logic [OUT_W-1:0] b_q
);

    logic [OUT_W-1:0] low_mask;
    int               wlen;

    assign wlen = int'(word_bits) + 1;

    always_comb begin
        if (wlen >= OUT_W) low_mask = '0;
        else               low_mask = (OUT_W'(1) << (OUT_W - wlen)) - OUT_W'(1);
    end

    // R2: a completed word needs a strobed bit in the previous cycle
    p_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> $past(bit_en));

    // R4: short words leave the low output bits at zero
    p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> (((a_i & low_mask) == '0) && ((a_q & low_mask) == '0)));

    // R5: channel B completes together with channel A
    p_b_with_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> a_valid);

    // R9: channel A words hold between valid pulses
    p_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !a_valid |-> ($stable(a_i) && $stable(a_q)));

    // R10: channel B words hold between its pulses
    p_hold_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !b_valid |-> ($stable(b_i) && $stable(b_q)));

    // R10: channel B pulses only in two-channel mode
    p_b_dual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> ($past(mode) == 2'b00));

endmodule

bind iq_serial_deser iq_serial_deser_chk #(.MAX_BITS(MAX_BITS), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .word_bits (word_bits),
    .bit_en    (bit_en),
    .a_valid   (a_valid),
    .b_valid   (b_valid),
    .a_i       (a_i),
    .a_q       (a_q),
    .b_i       (b_i),
    .b_q       (b_q)
);

// File: tb/tb_iq_serial_deser.sv
`timescale 1ns/1ps
module tb_iq_serial_deser;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic [4:0]  word_bits;
    logic        bit_en, frame_start;
    logic        sd_a, sd_b, sd_c, sd_d;
    logic [17:0] a_i, a_q, b_i, b_q;
    logic        a_valid, b_valid;

    int n_chk  = 0;
    int n_fail = 0;
    logic [17:0] held_bi = '0, held_bq = '0;

    always #2.5 clk = ~clk;

    iq_serial_deser dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .word_bits(word_bits),
        .bit_en(bit_en), .frame_start(frame_start),
        .sd_a(sd_a), .sd_b(sd_b), .sd_c(sd_c), .sd_d(sd_d),
        .a_i(a_i), .a_q(a_q), .a_valid(a_valid),
        .b_i(b_i), .b_q(b_q), .b_valid(b_valid)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [5:0]  n;
        logic [31:0] ai;
        logic [31:0] aq;
        logic [31:0] bi;
        logic [31:0] bq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 6'd18, 32'h2A5C3,    32'h1F00F,    32'h3FFFF,    32'h00001},
        '{2'd0, 6'd32, 32'hDEADBEEF, 32'h12345678, 32'h80000001, 32'h7FFFFFFF},
        '{2'd1, 6'd16, 32'h8001,     32'h7FFE,     32'h0,        32'h0},
        '{2'd1, 6'd24, 32'hA5A5A5,   32'h5A5A5A,   32'h0,        32'h0},
        '{2'd2, 6'd18, 32'h25555,    32'h1AAAA,    32'h0,        32'h0},
        '{2'd2, 6'd17, 32'h1F0F0,    32'h0ABCD,    32'h0,        32'h0},
        '{2'd3, 6'd12, 32'h800,      32'hFFF,      32'h0,        32'h0},
        '{2'd2, 6'd1,  32'h1,        32'h0,        32'h0,        32'h0},
        '{2'd0, 6'd4,  32'h9,        32'h6,        32'hF,        32'h1}
    };

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected 18-bit output: word left-justified in 32 bits, top 18 kept
    function automatic logic [17:0] exp18(logic [31:0] w, int n);
        logic [31:0] lj;
        lj = w << (32 - n);
        return lj[31:14];
    endfunction

    // Bit k counted from the MSB; beyond the word a 1 is sent as filler
    function automatic logic bitof(logic [31:0] w, int n, int k);
        return (k < n) ? w[n-1-k] : 1'b1;
    endfunction

    // One strobed bit period followed by one unstrobed garbage cycle
    task automatic put_bit(logic a, logic b, logic c, logic d, logic fs);
        @(negedge clk);
        sd_a = a; sd_b = b; sd_c = c; sd_d = d;
        bit_en = 1'b1; frame_start = fs;
        @(negedge clk);
        bit_en = 1'b0; frame_start = 1'b1;
        sd_a = ~a; sd_b = ~b; sd_c = ~c; sd_d = ~d;
    endtask

    task automatic send_vec(vec_t v, string tag);
        int n = int'(v.n);
        int p;
        mode = v.md;
        word_bits = 5'(n - 1);
        if (v.md == 2'd0) begin
            for (int k = 0; k < 2*n; k++) begin
                if (k < n) put_bit(bitof(v.ai, n, k), bitof(v.bi, n, k), 1'b0, 1'b0, k == 0);
                else       put_bit(bitof(v.aq, n, k-n), bitof(v.bq, n, k-n), 1'b0, 1'b0, 1'b0);
            end
        end else if (v.md == 2'd2) begin
            p = (n + 1) / 2;
            for (int k = 0; k < p; k++)
                put_bit(bitof(v.ai, n, 2*k), bitof(v.ai, n, 2*k+1),
                        bitof(v.aq, n, 2*k), bitof(v.aq, n, 2*k+1), k == 0);
        end else begin
            for (int k = 0; k < n; k++)
                put_bit(bitof(v.ai, n, k), bitof(v.aq, n, k), 1'b0, 1'b0, k == 0);
        end
        chk(tag, "a_valid pulse", 32'(a_valid), 32'd1);
        chk(tag, "a_i", 32'(a_i), 32'(exp18(v.ai, n)));
        chk(tag, "a_q", 32'(a_q), 32'(exp18(v.aq, n)));
        if (v.md == 2'd0) begin
            held_bi = exp18(v.bi, n);
            held_bq = exp18(v.bq, n);
            chk(tag, "b_valid pulse", 32'(b_valid), 32'd1);
        end else begin
            chk("R10", "b_valid idle", 32'(b_valid), 32'd0);
        end
        chk(tag, "b_i", 32'(b_i), 32'(held_bi));
        chk(tag, "b_q", 32'(b_q), 32'(held_bq));
        @(negedge clk);
        chk("R9", "a_valid one cycle", 32'(a_valid), 32'd0);
    endtask

    function automatic string tag_of(logic [1:0] md, int n);
        if (md == 2'd0) return (n > 18) ? "R5/R3" : ((n < 18) ? "R5/R4" : "R5");
        if (md == 2'd2) return "R7";
        return (n > 18) ? "R6/R3" : ((n < 18) ? "R6/R4" : "R6");
    endfunction

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [17:0] keep_i, keep_q;
        rst_n = 1'b0; mode = 2'd0; word_bits = 5'd17;
        bit_en = 1'b0; frame_start = 1'b0;
        sd_a = 1'b0; sd_b = 1'b0; sd_c = 1'b0; sd_d = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "a_valid", 32'(a_valid), 32'd0);
        chk("R1", "b_valid", 32'(b_valid), 32'd0);
        chk("R1", "a_i", 32'(a_i), 32'd0);
        chk("R1", "b_q", 32'(b_q), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: garbage with frame_start high but no strobe
        frame_start = 1'b1; sd_a = 1'b1; sd_b = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2", "a_valid no strobe", 32'(a_valid), 32'd0);
        chk("R2", "a_i no strobe", 32'(a_i), 32'd0);
        frame_start = 1'b0;

        for (int i = 0; i < NV; i++) send_vec(TBL[i], tag_of(TBL[i].md, int'(TBL[i].n)));

        // R8: strobed bits in idle without frame_start are ignored
        mode = 2'd1; word_bits = 5'd3;
        keep_i = a_i; keep_q = a_q;
        for (int k = 0; k < 6; k++) begin
            put_bit(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R8", "no valid in idle", 32'(a_valid), 32'd0);
        end
        chk("R8", "a_i kept", 32'(a_i), 32'(keep_i));

        // R8: restart mid-word discards the partial word
        mode = 2'd1; word_bits = 5'd15;
        for (int k = 0; k < 7; k++) put_bit(1'b1, 1'b1, 1'b0, 1'b0, k == 0);
        chk("R8", "no valid on partial", 32'(a_valid), 32'd0);
        send_vec('{2'd1, 6'd16, 32'h1234, 32'h0F0F, 32'h0, 32'h0}, "R8");

        // R8/R7: restart mid-word in four-pin mode
        mode = 2'd2; word_bits = 5'd17;
        for (int k = 0; k < 4; k++) put_bit(1'b1, 1'b1, 1'b1, 1'b1, k == 0);
        send_vec('{2'd2, 6'd18, 32'h00003, 32'h20000, 32'h0, 32'h0}, "R8/R7");

        // R9: back-to-back one-bit words on consecutive strobes
        mode = 2'd1; word_bits = 5'd0;
        @(negedge clk);
        bit_en = 1'b1; frame_start = 1'b1; sd_a = 1'b1; sd_b = 1'b0;
        @(negedge clk);
        chk("R9", "first pulse", 32'(a_valid), 32'd1);
        chk("R9", "first a_i", 32'(a_i), 32'h20000);
        sd_a = 1'b0; sd_b = 1'b1;
        @(negedge clk);
        chk("R9", "second pulse", 32'(a_valid), 32'd1);
        chk("R9", "second a_i", 32'(a_i), 32'h0);
        chk("R9", "second a_q", 32'(a_q), 32'h20000);
        bit_en = 1'b0; frame_start = 1'b0;
        @(negedge clk);
        chk("R9", "pulse ends", 32'(a_valid), 32'd0);
        chk("R10", "b_i held", 32'(b_i), 32'(held_bi));

        // R1: reset clears outputs again
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "a_q after reset", 32'(a_q), 32'd0);
        chk("R1", "b_i after reset", 32'(b_i), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule